// File: doc/BRIEF.md
# Streaming Audio Input Block Stager

This block takes streamed audio input for one mixing core and places it in a double-buffered input area of the sound RAM. A host transfer is started with a word count. The count is rounded down to whole blocks of 512 words. Each block then arrives as a stream of 16-bit words, and every accepted word is written into the input area one cycle later. The half of the double buffer that receives the block is chosen from the mixer's current read position, so that the mixer never reads the half being filled.

There are two layouts. In split layout, a block carries 256 left-channel samples followed by 256 right-channel samples. The left samples go to the left region at the free-half offset, and the right samples go to the same offset 512 words further on. In unsplit layout, the 512 words are stored contiguously from twice the free-half offset.

The block also keeps a remaining-input count and the host memory address, both updated after every 256 words. Once a block has been staged, the mixer can ask for the next one from the remaining input. If the core's streaming enable is clear, a start only points the transfer start address at the core's input area and records the completion count.

Top module: `adma_stager`

## Requirements
- R1: While reset is asserted and after its release, `remain`, `comp_cnt`, `start_addr`, `host_addr`, `din_ready`, `ram_we`, `blk_req` and `stream_active` are all zero.
- R2: Streaming is enabled when `ctrl_bits[CORE_IDX]` is 1 (core 0 tests bit 0, core 1 tests bit 1). A start while streaming is disabled has three effects one cycle later. It sets `start_addr` to 0x2000 + CORE_IDX*1024. It sets `comp_cnt` to the rounded size. It clears `stream_active`. It stages nothing.
- R3: The transfer size is `xfer_len` rounded down to a multiple of 512. An enabled start with a size of at least 512 loads `remain` with that size one cycle later.
- R4: At the cycle a block starts, the free-half offset is taken as ((mix_pos + 255) AND 256), which is either 0 or 256.
- R5: In split layout (`unsplit`=0), word k of a block (0..511) is written to 0x2000 + CORE_IDX*1024 + offset + k for k < 256, and to that address + 256 for k >= 256.
- R6: In unsplit layout (`unsplit`=1), word k of a block is written to 0x2000 + CORE_IDX*1024 + 2*offset + k.
- R7: After the 256th and the 512th accepted word of a block, `remain` drops by 256 and `host_addr` rises by 256, one cycle after the accepting edge. `madr_ld` loads `host_addr` when no block is being staged.
- R8: An enabled start with a rounded size of 0 sets `remain` to 0 and `comp_cnt` to 1, and stages nothing.
- R9: An enabled start with a size of at least 512 stages a block only when `stream_active` is 0, and then sets `stream_active`. If that size is exactly 512, `comp_cnt` becomes 512; otherwise `comp_cnt` is unchanged.
- R10: `blk_req` pulses for one cycle, together with the write of a block's last word, exactly when `remain` is then nonzero.
- R11: `refill` while idle, active and with `remain` nonzero starts staging another block. In any other state it has no effect.
- R12: `xfer_start` while a block is being staged is ignored.
- R13: A word accepted (`din_valid` and `din_ready` at a clock edge) appears on `ram_we`/`ram_wdata` in the next cycle. `din_ready` is high exactly while a block is being staged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_bits | input | 2 | Per-core streaming enable bits |
| unsplit | input | 1 | 1 = contiguous layout, 0 = left/right split |
| xfer_start | input | 1 | Start pulse for a host transfer |
| xfer_len | input | 20 | Transfer length in words |
| madr_ld | input | 1 | Load host address |
| madr_val | input | 32 | Host address load value |
| mix_pos | input | 9 | Mixer read position in the double buffer |
| refill | input | 1 | Mixer request to stage the next block |
| din_valid | input | 1 | Stream word valid |
| din_data | input | 16 | Stream word |
| din_ready | output | 1 | Block is being staged, word accepted |
| ram_we | output | 1 | Sound RAM write strobe |
| ram_addr | output | 20 | Sound RAM word address |
| ram_wdata | output | 16 | Sound RAM write data |
| remain | output | 20 | Remaining input words |
| comp_cnt | output | 20 | Completion count of the last start |
| start_addr | output | 20 | Transfer start address |
| host_addr | output | 32 | Host memory word address |
| stream_active | output | 1 | Streaming transfer in progress |
| blk_req | output | 1 | Request for the next block |

## Verification
Every result here is due exactly one cycle after the edge that caused it. That covers the start effects on `remain`, `comp_cnt`, `start_addr`, `stream_active` and `din_ready`, the RAM write for an accepted word, the half-block update of `remain` and `host_addr`, and the `blk_req` pulse. The bench drives inputs on the falling edge and checks on the next falling edge, so each check lands in the single cycle its result is due. Idle gaps between stream words are checked for the absence of a write. The half-block and last-word checks sit in the same falling-edge slot as the write of word 256 or 512.

// File: rtl/adma_stage_pkg.sv
package adma_stage_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_FILL = 1'b1
  } fill_state_e;
endpackage

// File: rtl/adma_half_sel.sv
// Picks the half of the double buffer the mixer is not reading.
module adma_half_sel #(
  parameter int BLK_WORDS = 512,
  localparam int POS_W = $clog2(BLK_WORDS),
  localparam int HALF = BLK_WORDS / 2
) (
  input  logic [POS_W-1:0] rd_pos_i,
  output logic [POS_W-1:0] free_ofs_o
);
  logic [POS_W:0] rounded;

  always_comb begin
    rounded    = {1'b0, rd_pos_i} + (POS_W+1)'(HALF - 1);
    free_ofs_o = rounded[POS_W-1:0] & POS_W'(HALF);
  end
endmodule

// File: rtl/adma_addr_gen.sv
// Word counter and RAM address generation for one block.
module adma_addr_gen #(
  parameter int BLK_WORDS = 512,
  parameter int ADDR_W = 20,
  parameter logic [ADDR_W-1:0] CORE_BASE = '0,
  localparam int POS_W = $clog2(BLK_WORDS),
  localparam int HALF = BLK_WORDS / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [POS_W-1:0]  load_ofs_i,
  input  logic              load_unsplit_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic              half_last_o,
  output logic              blk_last_o
);
  logic [POS_W-1:0] word_q, word_d;
  logic [POS_W-1:0] ofs_q, ofs_d;
  logic             unsplit_q, unsplit_d;

  always_comb begin
    word_d    = word_q;
    ofs_d     = ofs_q;
    unsplit_d = unsplit_q;
    if (load_i) begin
      word_d    = '0;
      ofs_d     = load_ofs_i;
      unsplit_d = load_unsplit_i;
    end else if (step_i) begin
      word_d = word_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q    <= '0;
      ofs_q     <= '0;
      unsplit_q <= 1'b0;
    end else begin
      word_q    <= word_d;
      ofs_q     <= ofs_d;
      unsplit_q <= unsplit_d;
    end
  end

  always_comb begin
    if (unsplit_q) begin
      wr_addr_o = CORE_BASE + (ADDR_W'(ofs_q) << 1) + ADDR_W'(word_q);
    end else begin
      wr_addr_o = CORE_BASE + ADDR_W'(ofs_q) + ADDR_W'(word_q)
                + (word_q[POS_W-1] ? ADDR_W'(HALF) : '0);
    end
    half_last_o = (word_q[POS_W-2:0] == {(POS_W-1){1'b1}});
    blk_last_o  = (word_q == {POS_W{1'b1}});
  end
endmodule

// File: rtl/adma_fill_ctl.sv
// Transfer start decode, staging state, counters and host address.
module adma_fill_ctl
  import adma_stage_pkg::*;
#(
  parameter int BLK_WORDS = 512,
  parameter int LEN_W = 20,
  parameter int ADDR_W = 20,
  parameter int HOST_W = 32,
  parameter logic [ADDR_W-1:0] CORE_BASE = '0,
  localparam int HALF = BLK_WORDS / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              auto_en_i,
  input  logic              refill_i,
  input  logic              madr_ld_i,
  input  logic [HOST_W-1:0] madr_val_i,
  input  logic              beat_i,
  input  logic              half_last_i,
  input  logic              blk_last_i,
  output logic              load_o,
  output logic              filling_o,
  output logic [LEN_W-1:0]  remain_o,
  output logic [LEN_W-1:0]  comp_o,
  output logic [ADDR_W-1:0] start_addr_o,
  output logic [HOST_W-1:0] host_o,
  output logic              active_o,
  output logic              blk_req_o
);
  localparam logic [LEN_W-1:0] SIZE_MASK = ~LEN_W'(BLK_WORDS - 1);
  localparam logic [LEN_W-1:0] LEN_BLK   = LEN_W'(BLK_WORDS);
  localparam logic [LEN_W-1:0] LEN_HALF  = LEN_W'(HALF);

  fill_state_e       state_q, state_d;
  logic [LEN_W-1:0]  remain_q, remain_d;
  logic [LEN_W-1:0]  comp_q, comp_d;
  logic [ADDR_W-1:0] saddr_q, saddr_d;
  logic [HOST_W-1:0] host_q, host_d;
  logic              active_q, active_d;
  logic              req_q, req_d;
  logic [LEN_W-1:0]  size;
  logic              idle, start_ok, start_stage, refill_stage;

  always_comb begin
    size         = len_i & SIZE_MASK;
    idle         = (state_q == ST_IDLE);
    start_ok     = start_i && idle;
    start_stage  = start_ok && auto_en_i && (size != '0) && !active_q;
    refill_stage = !start_ok && idle && refill_i && active_q && (remain_q != '0);
    load_o       = start_stage || refill_stage;
  end

  always_comb begin
    state_d  = state_q;
    remain_d = remain_q;
    comp_d   = comp_q;
    saddr_d  = saddr_q;
    host_d   = host_q;
    active_d = active_q;
    req_d    = 1'b0;

    if (start_ok) begin
      if (!auto_en_i) begin
        saddr_d  = CORE_BASE;
        comp_d   = size;
        active_d = 1'b0;
      end else if (size != '0) begin
        remain_d = size;
        if (!active_q && (size == LEN_BLK)) begin
          comp_d = size;
        end
        active_d = 1'b1;
      end else begin
        remain_d = '0;
        comp_d   = LEN_W'(1);
      end
    end

    if (idle && madr_ld_i) begin
      host_d = madr_val_i;
    end

    if (beat_i && half_last_i) begin
      remain_d = remain_q - LEN_HALF;
      host_d   = host_q + HOST_W'(HALF);
    end

    if (load_o) begin
      state_d = ST_FILL;
    end else if (!idle && beat_i && blk_last_i) begin
      state_d = ST_IDLE;
      req_d   = ((remain_q - LEN_HALF) != '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      remain_q <= '0;
      comp_q   <= '0;
      saddr_q  <= '0;
      host_q   <= '0;
      active_q <= 1'b0;
      req_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      remain_q <= remain_d;
      comp_q   <= comp_d;
      saddr_q  <= saddr_d;
      host_q   <= host_d;
      active_q <= active_d;
      req_q    <= req_d;
    end
  end

  assign filling_o    = (state_q == ST_FILL);
  assign remain_o     = remain_q;
  assign comp_o       = comp_q;
  assign start_addr_o = saddr_q;
  assign host_o       = host_q;
  assign active_o     = active_q;
  assign blk_req_o    = req_q;
endmodule

// File: rtl/adma_stager.sv
module adma_stager #(
  parameter int CORE_IDX = 0,
  parameter int NUM_CORES = 2,
  parameter int BLK_WORDS = 512,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 20,
  parameter int LEN_W = 20,
  parameter int HOST_W = 32,
  parameter int AREA_BASE = 'h2000,
  parameter int AREA_STRIDE = 1024,
  localparam int POS_W = $clog2(BLK_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CORES-1:0] ctrl_bits,
  input  logic              unsplit,
  input  logic              xfer_start,
  input  logic [LEN_W-1:0]  xfer_len,
  input  logic              madr_ld,
  input  logic [HOST_W-1:0] madr_val,
  input  logic [POS_W-1:0]  mix_pos,
  input  logic              refill,
  input  logic              din_valid,
  input  logic [DATA_W-1:0] din_data,
  output logic              din_ready,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  output logic [LEN_W-1:0]  remain,
  output logic [LEN_W-1:0]  comp_cnt,
  output logic [ADDR_W-1:0] start_addr,
  output logic [HOST_W-1:0] host_addr,
  output logic              stream_active,
  output logic              blk_req
);
  localparam logic [ADDR_W-1:0] CORE_BASE = ADDR_W'(AREA_BASE + CORE_IDX * AREA_STRIDE);

  logic             auto_en, load, filling, beat, half_last, blk_last;
  logic [POS_W-1:0] free_ofs;
  logic [ADDR_W-1:0] gen_addr;
  logic              we_q, we_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] data_q, data_d;

  assign auto_en = ctrl_bits[CORE_IDX];
  assign beat    = din_valid && filling;

  adma_half_sel #(.BLK_WORDS(BLK_WORDS)) half_sel_i (
    .rd_pos_i  (mix_pos),
    .free_ofs_o(free_ofs)
  );

  adma_addr_gen #(
    .BLK_WORDS(BLK_WORDS), .ADDR_W(ADDR_W), .CORE_BASE(CORE_BASE)
  ) addr_gen_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .load_i        (load),
    .load_ofs_i    (free_ofs),
    .load_unsplit_i(unsplit),
    .step_i        (beat),
    .wr_addr_o     (gen_addr),
    .half_last_o   (half_last),
    .blk_last_o    (blk_last)
  );

  adma_fill_ctl #(
    .BLK_WORDS(BLK_WORDS), .LEN_W(LEN_W), .ADDR_W(ADDR_W),
    .HOST_W(HOST_W), .CORE_BASE(CORE_BASE)
  ) ctl_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (xfer_start),
    .len_i       (xfer_len),
    .auto_en_i   (auto_en),
    .refill_i    (refill),
    .madr_ld_i   (madr_ld),
    .madr_val_i  (madr_val),
    .beat_i      (beat),
    .half_last_i (half_last),
    .blk_last_i  (blk_last),
    .load_o      (load),
    .filling_o   (filling),
    .remain_o    (remain),
    .comp_o      (comp_cnt),
    .start_addr_o(start_addr),
    .host_o      (host_addr),
    .active_o    (stream_active),
    .blk_req_o   (blk_req)
  );

  // registered RAM write port
  always_comb begin
    we_d   = beat;
    addr_d = addr_q;
    data_d = data_q;
    if (beat) begin
      addr_d = gen_addr;
      data_d = din_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      we_q   <= we_d;
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  assign din_ready = filling;
  assign ram_we    = we_q;
  assign ram_addr  = addr_q;
  assign ram_wdata = data_q;
endmodule

// File: rtl/adma_stage_chk.sv
module adma_stage_chk #(
  parameter int CORE_IDX = 0,
  parameter int NUM_CORES = 2,
  parameter int BLK_WORDS = 512,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 20,
  parameter int LEN_W = 20,
  parameter int HOST_W = 32,
  parameter int AREA_BASE = 'h2000,
  parameter int AREA_STRIDE = 1024,
  localparam int POS_W = $clog2(BLK_WORDS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CORES-1:0] ctrl_bits,
  input logic              xfer_start,
  input logic [LEN_W-1:0]  xfer_len,
  input logic              din_valid,
  input logic              din_ready,
  input logic              ram_we,
  input logic [ADDR_W-1:0] ram_addr,
  input logic [LEN_W-1:0]  remain,
  input logic [LEN_W-1:0]  comp_cnt,
  input logic [ADDR_W-1:0] start_addr,
  input logic              stream_active,
  input logic              blk_req
);
  localparam logic [ADDR_W-1:0] CORE_BASE = ADDR_W'(AREA_BASE + CORE_IDX * AREA_STRIDE);
  localparam logic [ADDR_W-1:0] CORE_END  = CORE_BASE + ADDR_W'(2 * BLK_WORDS);

  assert_ready_needs_active_R9: assert property (@(posedge clk) disable iff (!rst_n)
    din_ready |-> stream_active);

  assert_write_after_beat_R13: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> $past(din_valid && din_ready));

  assert_write_in_area_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (ram_addr >= CORE_BASE) && (ram_addr < CORE_END));

  assert_req_has_input_R10: assert property (@(posedge clk) disable iff (!rst_n)
    blk_req |-> (remain != '0));

  assert_disabled_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_start && !din_ready && !ctrl_bits[CORE_IDX])
      |=> (start_addr == CORE_BASE) && !stream_active && !din_ready);

  assert_remain_no_growth_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_start |=> (remain <= $past(remain)));

  assert_short_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_start && !din_ready && ctrl_bits[CORE_IDX] && (xfer_len < LEN_W'(BLK_WORDS)))
      |=> (remain == '0) && (comp_cnt == LEN_W'(1)));
endmodule

bind adma_stager adma_stage_chk #(
  .CORE_IDX(CORE_IDX), .NUM_CORES(NUM_CORES), .BLK_WORDS(BLK_WORDS),
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .HOST_W(HOST_W),
  .AREA_BASE(AREA_BASE), .AREA_STRIDE(AREA_STRIDE)
) chk_i (.*);

// File: tb/adma_stager_tb.sv
module adma_stager_tb_top;
  localparam int BASE = 'h2000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  ctrl_bits;
  logic        unsplit, xfer_start, madr_ld, refill, din_valid;
  logic [19:0] xfer_len;
  logic [31:0] madr_val;
  logic [8:0]  mix_pos;
  logic [15:0] din_data;
  logic        din_ready, ram_we, stream_active, blk_req;
  logic [19:0] ram_addr, remain, comp_cnt, start_addr;
  logic [15:0] ram_wdata;
  logic [31:0] host_addr;

  int total = 0;
  int bad = 0;

  int m_remain, m_comp;
  logic [31:0] m_host;
  bit m_active;

  always #5 clk = ~clk;

  adma_stager dut_i (
    .clk(clk), .rst_n(rst_n), .ctrl_bits(ctrl_bits), .unsplit(unsplit),
    .xfer_start(xfer_start), .xfer_len(xfer_len), .madr_ld(madr_ld),
    .madr_val(madr_val), .mix_pos(mix_pos), .refill(refill),
    .din_valid(din_valid), .din_data(din_data), .din_ready(din_ready),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .remain(remain), .comp_cnt(comp_cnt), .start_addr(start_addr),
    .host_addr(host_addr), .stream_active(stream_active), .blk_req(blk_req)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int free_ofs(input int pos);
    return (pos + 255) & 256;
  endfunction

  function automatic int exp_addr(input int k, input int ofs, input bit us);
    if (us) return BASE + 2 * ofs + k;
    return BASE + ofs + k + ((k >= 256) ? 256 : 0);
  endfunction

  // stream one block; optionally poke a start mid-block (R12)
  task automatic fill_block(input int pos, input bit us, input bit poke);
    int ofs = free_ofs(pos);
    for (int k = 0; k < 512; k++) begin
      logic [15:0] d = 16'($urandom);
      if ($urandom % 5 == 0) begin
        din_valid = 1'b0;
        @(negedge clk);
        chk(ram_we == 1'b0, "R13 idle gap", ram_we, 0);
      end
      din_valid = 1'b1;
      din_data  = d;
      if (poke && k == 100) begin
        xfer_start = 1'b1; xfer_len = 20'd4096; ctrl_bits = 2'b01;
      end
      @(negedge clk);
      xfer_start = 1'b0;
      chk(ram_we && ram_wdata == d, "R13 write data", ram_wdata, d);
      chk(ram_addr == 20'(exp_addr(k, ofs, us)), us ? "R6 unsplit addr" : "R5 split addr",
          ram_addr, exp_addr(k, ofs, us));
      if (k == 255 || k == 511) begin
        m_remain -= 256;
        m_host   += 256;
        chk(remain == 20'(m_remain), "R7 remain step (R12 ignored start)", remain, m_remain);
        chk(host_addr == m_host, "R7 host step", host_addr, m_host);
      end
      if (k == 511) begin
        chk(blk_req == (m_remain != 0), "R10 block request", blk_req, m_remain != 0);
        chk(din_ready == 1'b0, "R13 ready drops", din_ready, 0);
      end else begin
        chk(blk_req == 1'b0, "R10 no early request", blk_req, 0);
      end
    end
    din_valid = 1'b0;
    @(negedge clk);
    chk(blk_req == 1'b0 && ram_we == 1'b0, "R10 one-cycle pulse", blk_req, 0);
  endtask

  task automatic do_start(input int len, input logic [1:0] cb, input int pos, input bit us);
    int size = len & ~511;
    bit stage = 1'b0;
    ctrl_bits = cb; xfer_len = 20'(len); mix_pos = 9'(pos); unsplit = us;
    xfer_start = 1'b1;
    @(negedge clk);
    xfer_start = 1'b0;
    if (!cb[0]) begin
      m_comp = size; m_active = 1'b0;
      chk(start_addr == 20'(BASE), "R2 start address", start_addr, BASE);
    end else if (size != 0) begin
      m_remain = size;
      stage = !m_active;
      if (stage && size == 512) m_comp = 512;
      m_active = 1'b1;
    end else begin
      m_remain = 0; m_comp = 1;
    end
    chk(remain == 20'(m_remain), "R3 remain after start", remain, m_remain);
    chk(comp_cnt == 20'(m_comp), "R9 completion count", comp_cnt, m_comp);
    chk(stream_active == m_active, "R9 active flag", stream_active, m_active);
    chk(din_ready == stage, "R9 staging begins", din_ready, stage);
    if (stage) fill_block(pos, us, 1'b0);
  endtask

  task automatic do_refill(input int pos, input bit us);
    bit stage = m_active && (m_remain != 0);
    mix_pos = 9'(pos); unsplit = us; refill = 1'b1;
    @(negedge clk);
    refill = 1'b0;
    chk(din_ready == stage, "R11 refill", din_ready, stage);
    if (stage) fill_block(pos, us, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd2024);
    rst_n = 1'b0; ctrl_bits = '0; unsplit = 0; xfer_start = 0; xfer_len = '0;
    madr_ld = 0; madr_val = '0; mix_pos = '0; refill = 0; din_valid = 0; din_data = '0;
    m_remain = 0; m_comp = 0; m_host = '0; m_active = 0;
    repeat (3) @(negedge clk);
    chk(remain == 0 && comp_cnt == 0 && !din_ready && !ram_we && !blk_req
        && !stream_active && host_addr == 0 && start_addr == 0, "R1 reset state", remain, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(remain == 0 && !din_ready && !stream_active, "R1 after release", remain, 0);

    madr_val = 32'h0001_0000; madr_ld = 1'b1; m_host = 32'h0001_0000;
    @(negedge clk);
    madr_ld = 1'b0;
    chk(host_addr == m_host, "R7 host load", host_addr, m_host);

    do_start(1000, 2'b10, 0, 0);              // R2: bit 1 does not enable core 0
    do_start(300, 2'b01, 0, 0);               // R8 short transfer
    // R4 pos=10 -> offset 256; split; poke start mid-block for R12
    ctrl_bits = 2'b01; xfer_len = 20'd1124; mix_pos = 9'd10; unsplit = 0;
    xfer_start = 1'b1;
    @(negedge clk);
    xfer_start = 1'b0;
    m_remain = 1024; m_active = 1;
    chk(remain == 20'd1024 && comp_cnt == 20'd1, "R3 rounded size", remain, 1024);
    fill_block(10, 0, 1'b1);
    do_start(512, 2'b01, 0, 0);               // R9: active, no new staging
    do_refill(300, 1);                        // R4 offset 0, R6 unsplit, R11
    do_refill(40, 0);                         // R11: remain 0 -> ignored
    do_start(0, 2'b00, 0, 0);                 // R2 clears active
    do_start(512, 2'b01, 200, 1);             // R9 size 512 completion count
    do_start(0, 2'b00, 0, 0);

    for (int it = 0; it < 5; it++) begin
      do_start(int'($urandom % 3000), 2'b01, int'($urandom % 512), bit'($urandom % 2));
      while (m_remain != 0) do_refill(int'($urandom % 512), bit'($urandom % 2));
      do_refill(int'($urandom % 512), 0);
      do_start(int'($urandom % 2048), 2'b00, 0, 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule